// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This sequencer sits beside a banked register file. It decides whether a processor reset, a fast interrupt or a normal interrupt is entered. When one is entered, it supplies the register file with four values in one package: the new status word, the status word to be saved into the target mode's saved-status register, the link value and the new program counter.

The interrupt request lines are level-sensitive. They are evaluated only when the core signals an instruction boundary, and at most one entry is produced per boundary. A reset request is evaluated on every cycle, needs no boundary, and overrides both interrupt sources.

The status word uses the usual layout. Bits [4:0] hold the mode: 0x10 user, 0x11 fast-interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined, 0x1F system. Bit 7 is the normal-interrupt mask and bit 6 is the fast-interrupt mask. The register file selects the saved-status and link registers of the target mode from the mode field of the new status.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When `fast_req` is high at a boundary and status bit 6 is clear, a fast entry is taken. When bit 6 is set, no fast entry is taken.
- R2: When `norm_req` is high at a boundary and status bit 7 is clear, a normal entry is taken. When bit 7 is set, no normal entry is taken.
- R3: When both kinds are requested and unmasked, the fast entry wins. A fast request inside a normal-interrupt handler (mode 0x12, bit 7 set, bit 6 clear) is taken. A normal request inside a fast handler (bits 7 and 6 set) is not taken.
- R4: On a fast entry the new status carries mode 0x11 with bits 7 and 6 set, keeps all other bits, and the vector is 0x0000001C.
- R5: On a normal entry the new status carries mode 0x12 with bit 7 set, leaves bit 6 and all other bits unchanged, and the vector is 0x00000018.
- R6: On either interrupt entry the saved status equals the status before entry, and the link value equals the current PC plus 4.
- R7: A reset request is taken on any cycle, with or without a boundary, and takes priority over both interrupts. On a reset entry the link value is the current PC, the saved status is the current status, the new status is 0x000000D3 and the vector is 0.
- R8: If the status mode field holds a code outside the seven legal modes when a reset is taken, the saved status is 0x000000D3 instead of the current status.
- R9: No entry is produced in a cycle with neither a boundary nor a reset request, and a single boundary produces at most one entry.
- R10: `take` is high for exactly the one cycle after the clock edge that sampled the request, and the data outputs are valid in that cycle. `kind` encodes the entry as 0 none, 1 reset, 2 fast, 3 normal. While `rst_n` is low, `take` is 0.
- R11: A request line that stays high while its mask is set is taken at the first boundary after the mask is cleared. No new edge on the line is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the controller registers |
| cpu_reset | input | 1 | Processor reset request, sampled every cycle |
| fast_req | input | 1 | Level-sensitive fast interrupt request |
| norm_req | input | 1 | Level-sensitive normal interrupt request |
| boundary | input | 1 | Instruction boundary strobe |
| cur_status | input | DATA_W | Current status word |
| cur_pc | input | DATA_W | Current program counter |
| take | output | 1 | Entry strobe to the register file |
| kind | output | 2 | Entry kind: 0 none, 1 reset, 2 fast, 3 normal |
| new_status | output | DATA_W | Status word to load |
| saved_status | output | DATA_W | Value for the target mode's saved-status register |
| link_val | output | DATA_W | Value for the target mode's link register |
| vector_addr | output | DATA_W | New program counter |

## Verification
The bench covers the following cases:
- **Preemption in both directions.** A fast request inside a normal-interrupt handler must be entered. A normal request inside a fast handler must not be. A design that tests the wrong mask bit, or lets the normal source win a tie, shows the wrong kind or a spurious strobe.
- **Reset with an illegal mode code.** A reset taken while the mode field holds an illegal code must save the substituted supervisor word. A missing substitution leaks the garbage status into the saved register.
- **Reset without a boundary while interrupts are pending.** A design that gates reset by the boundary strobe misses the entry. A design that ranks reset below the interrupts returns a fast or normal entry instead.
- **Held line unmasked later.** A request held high through a masked boundary must be taken once the mask clears. A design that waits for an edge on the line never takes it.
- **Preserved status bits.** Upper flag bits and bit 5 must be kept through both entries, which exposes a design that rebuilds the whole status word.

// File: rtl/exc_pkg.sv
package exc_pkg;

   typedef enum logic [1:0] {
      ENT_NONE  = 2'd0,
      ENT_RESET = 2'd1,
      ENT_FAST  = 2'd2,
      ENT_NORM  = 2'd3
   } entry_kind_t;

   localparam int MODE_W = 5;

   localparam logic [MODE_W-1:0] MODE_USER  = 5'h10;
   localparam logic [MODE_W-1:0] MODE_FAST  = 5'h11;
   localparam logic [MODE_W-1:0] MODE_NORM  = 5'h12;
   localparam logic [MODE_W-1:0] MODE_SUPER = 5'h13;
   localparam logic [MODE_W-1:0] MODE_ABORT = 5'h17;
   localparam logic [MODE_W-1:0] MODE_UNDEF = 5'h1B;
   localparam logic [MODE_W-1:0] MODE_SYS   = 5'h1F;

   localparam int NUM_LEGAL = 7;

endpackage

// File: rtl/exc_line_sync.sv
module exc_line_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '0;
            end else begin
               sh[0] <= d;
               for (int k = 1; k < STAGES; k++) begin
                  sh[k] <= sh[k-1];
               end
            end
         end
         assign q = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/exc_mode_decode.sv
module exc_mode_decode
   import exc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] status,
   output logic              legal
);

   localparam logic [NUM_LEGAL-1:0][MODE_W-1:0] LEGAL_SET =
      {MODE_SYS, MODE_UNDEF, MODE_ABORT, MODE_SUPER, MODE_NORM, MODE_FAST, MODE_USER};

   logic [MODE_W-1:0]    mode;
   logic [NUM_LEGAL-1:0] hit;

   assign mode = status[MODE_W-1:0];

   generate
      for (genvar g = 0; g < NUM_LEGAL; g++) begin : g_cmp
         assign hit[g] = (mode == LEGAL_SET[g]);
      end
   endgenerate

   assign legal = |hit;

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int I_POS  = 7,
   parameter int F_POS  = 6
) (
   input  logic              cpu_reset,
   input  logic              boundary,
   input  logic              fast_lvl,
   input  logic              norm_lvl,
   input  logic [DATA_W-1:0] status,
   output entry_kind_t       pick
);

   logic fast_open;
   logic norm_open;

   assign fast_open = boundary && fast_lvl && !status[F_POS];
   assign norm_open = boundary && norm_lvl && !status[I_POS];

   always_comb begin
      if (cpu_reset) begin
         pick = ENT_RESET;
      end else if (fast_open) begin
         pick = ENT_FAST;
      end else if (norm_open) begin
         pick = ENT_NORM;
      end else begin
         pick = ENT_NONE;
      end
   end

endmodule

// File: rtl/exc_frame_gen.sv
module exc_frame_gen
   import exc_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter int                I_POS     = 7,
   parameter int                F_POS     = 6,
   parameter int                LINK_OFS  = 4,
   parameter logic [DATA_W-1:0] FAST_VEC  = 'h1C,
   parameter logic [DATA_W-1:0] NORM_VEC  = 'h18,
   parameter logic [DATA_W-1:0] RESET_VEC = 'h0
) (
   input  entry_kind_t       pick,
   input  logic [DATA_W-1:0] status,
   input  logic [DATA_W-1:0] pc,
   input  logic              mode_legal,
   output logic [DATA_W-1:0] nxt_status,
   output logic [DATA_W-1:0] nxt_saved,
   output logic [DATA_W-1:0] nxt_link,
   output logic [DATA_W-1:0] nxt_vec
);

   localparam logic [DATA_W-1:0] MODE_MASK = DATA_W'({MODE_W{1'b1}});
   localparam logic [DATA_W-1:0] I_MASK    = DATA_W'(1) << I_POS;
   localparam logic [DATA_W-1:0] F_MASK    = DATA_W'(1) << F_POS;
   localparam logic [DATA_W-1:0] SUPER_ST  = I_MASK | F_MASK | DATA_W'(MODE_SUPER);

   logic [DATA_W-1:0] kept;

   assign kept = status & ~MODE_MASK;

   always_comb begin
      nxt_status = status;
      nxt_saved  = status;
      nxt_link   = pc + DATA_W'(LINK_OFS);
      nxt_vec    = pc;
      unique case (pick)
         ENT_RESET: begin
            nxt_status = SUPER_ST;
            nxt_saved  = mode_legal ? status : SUPER_ST;
            nxt_link   = pc;
            nxt_vec    = RESET_VEC;
         end
         ENT_FAST: begin
            nxt_status = kept | I_MASK | F_MASK | DATA_W'(MODE_FAST);
            nxt_vec    = FAST_VEC;
         end
         ENT_NORM: begin
            nxt_status = kept | I_MASK | DATA_W'(MODE_NORM);
            nxt_vec    = NORM_VEC;
         end
         default: begin
            nxt_vec = pc;
         end
      endcase
   end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter int                I_POS       = 7,
   parameter int                F_POS       = 6,
   parameter int                LINK_OFS    = 4,
   parameter int                SYNC_STAGES = 0,
   parameter logic [DATA_W-1:0] FAST_VEC    = 'h1C,
   parameter logic [DATA_W-1:0] NORM_VEC    = 'h18,
   parameter logic [DATA_W-1:0] RESET_VEC   = 'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_reset,
   input  logic              fast_req,
   input  logic              norm_req,
   input  logic              boundary,
   input  logic [DATA_W-1:0] cur_status,
   input  logic [DATA_W-1:0] cur_pc,
   output logic              take,
   output logic [1:0]        kind,
   output logic [DATA_W-1:0] new_status,
   output logic [DATA_W-1:0] saved_status,
   output logic [DATA_W-1:0] link_val,
   output logic [DATA_W-1:0] vector_addr
);

   initial begin
      a_param_check: assert (DATA_W >= 8 && I_POS != F_POS &&
                             I_POS >= MODE_W && F_POS >= MODE_W &&
                             I_POS < DATA_W && F_POS < DATA_W &&
                             SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("exc_entry_ctrl: illegal parameter set");
   end

   logic              fast_lvl;
   logic              norm_lvl;
   logic              mode_legal;
   entry_kind_t       pick;
   logic [DATA_W-1:0] nxt_status;
   logic [DATA_W-1:0] nxt_saved;
   logic [DATA_W-1:0] nxt_link;
   logic [DATA_W-1:0] nxt_vec;

   exc_line_sync #(.STAGES(SYNC_STAGES)) u_fast_sync (
      .clk(clk), .rst_n(rst_n), .d(fast_req), .q(fast_lvl)
   );

   exc_line_sync #(.STAGES(SYNC_STAGES)) u_norm_sync (
      .clk(clk), .rst_n(rst_n), .d(norm_req), .q(norm_lvl)
   );

   exc_mode_decode #(.DATA_W(DATA_W)) u_mode (
      .status(cur_status), .legal(mode_legal)
   );

   exc_arbiter #(.DATA_W(DATA_W), .I_POS(I_POS), .F_POS(F_POS)) u_arb (
      .cpu_reset(cpu_reset), .boundary(boundary),
      .fast_lvl(fast_lvl), .norm_lvl(norm_lvl),
      .status(cur_status), .pick(pick)
   );

   exc_frame_gen #(
      .DATA_W(DATA_W), .I_POS(I_POS), .F_POS(F_POS), .LINK_OFS(LINK_OFS),
      .FAST_VEC(FAST_VEC), .NORM_VEC(NORM_VEC), .RESET_VEC(RESET_VEC)
   ) u_frame (
      .pick(pick), .status(cur_status), .pc(cur_pc), .mode_legal(mode_legal),
      .nxt_status(nxt_status), .nxt_saved(nxt_saved),
      .nxt_link(nxt_link), .nxt_vec(nxt_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take         <= 1'b0;
         kind         <= ENT_NONE;
         new_status   <= '0;
         saved_status <= '0;
         link_val     <= '0;
         vector_addr  <= '0;
      end else begin
         take <= (pick != ENT_NONE);
         kind <= pick;
         if (pick != ENT_NONE) begin
            new_status   <= nxt_status;
            saved_status <= nxt_saved;
            link_val     <= nxt_link;
            vector_addr  <= nxt_vec;
         end
      end
   end

   // R1: unmasked fast request at a boundary yields a fast entry
   p_fast_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !cpu_reset && fast_lvl && !cur_status[F_POS])
      |=> (take && kind == ENT_FAST));

   // R1: fast mask set blocks fast entry
   p_fast_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_reset && cur_status[F_POS]) |=> (kind != ENT_FAST));

   // R2: normal mask set blocks normal entry
   p_norm_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_reset && cur_status[I_POS]) |=> (kind != ENT_NORM));

   // R3: fast wins over normal
   p_fast_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !cpu_reset && fast_lvl && !cur_status[F_POS] &&
       norm_lvl && !cur_status[I_POS]) |=> (kind == ENT_FAST));

   // R6: link and saved status on interrupt entry
   p_link_saved_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !cpu_reset &&
       ((fast_lvl && !cur_status[F_POS]) || (norm_lvl && !cur_status[I_POS])))
      |=> (link_val == $past(cur_pc) + DATA_W'(LINK_OFS) &&
           saved_status == $past(cur_status)));

   // R7: reset overrides everything and needs no boundary
   p_reset_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_reset |=> (take && kind == ENT_RESET && vector_addr == RESET_VEC &&
                     link_val == $past(cur_pc)));

   // R9: no request, no strobe
   p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!boundary && !cpu_reset) |=> !take);

   // R10: strobe and kind agree
   p_take_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (kind != ENT_NONE));

endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;

   localparam int CLK_P = 10;

   typedef struct {
      logic        tk;
      logic [1:0]  kd;
      logic [31:0] ns;
      logic [31:0] sv;
      logic [31:0] lk;
      logic [31:0] vc;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_reset = 1'b0;
   logic        fast_req = 1'b0;
   logic        norm_req = 1'b0;
   logic        boundary = 1'b0;
   logic [31:0] cur_status = 32'h0;
   logic [31:0] cur_pc = 32'h0;
   logic        take;
   logic [1:0]  kind;
   logic [31:0] new_status;
   logic [31:0] saved_status;
   logic [31:0] link_val;
   logic [31:0] vector_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   exp_t q[$];

   exc_entry_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cpu_reset(cpu_reset),
      .fast_req(fast_req), .norm_req(norm_req), .boundary(boundary),
      .cur_status(cur_status), .cur_pc(cur_pc),
      .take(take), .kind(kind), .new_status(new_status),
      .saved_status(saved_status), .link_val(link_val), .vector_addr(vector_addr)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic bit legal_mode(input logic [4:0] m);
      return m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
             m == 5'h17 || m == 5'h1B || m == 5'h1F;
   endfunction

   function automatic exp_t model(input logic b, input logic r, input logic f,
                                  input logic i, input logic [31:0] st,
                                  input logic [31:0] pc, input string tag);
      exp_t e;
      e.tk = 1'b0; e.kd = 2'd0; e.ns = 0; e.sv = 0; e.lk = 0; e.vc = 0; e.tag = tag;
      if (r) begin
         e.tk = 1'b1; e.kd = 2'd1; e.ns = 32'hD3;
         e.sv = legal_mode(st[4:0]) ? st : 32'hD3;
         e.lk = pc; e.vc = 32'h0;
      end else if (b && f && !st[6]) begin
         e.tk = 1'b1; e.kd = 2'd2;
         e.ns = {st[31:8], 1'b1, 1'b1, st[5], 5'h11};
         e.sv = st; e.lk = pc + 32'd4; e.vc = 32'h1C;
      end else if (b && i && !st[7]) begin
         e.tk = 1'b1; e.kd = 2'd3;
         e.ns = {st[31:8], 1'b1, st[6:5], 5'h12};
         e.sv = st; e.lk = pc + 32'd4; e.vc = 32'h18;
      end
      return e;
   endfunction

   task automatic drive(input logic b, input logic r, input logic f, input logic i,
                        input logic [31:0] st, input logic [31:0] pc, input string tag);
      @(negedge clk);
      boundary = b; cpu_reset = r; fast_req = f; norm_req = i;
      cur_status = st; cur_pc = pc;
      q.push_back(model(b, r, f, i, st, pc, tag));
   endtask

   task automatic cmp(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // monitor: one expected item per clock edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "take", {31'b0, take}, {31'b0, e.tk});
            if (e.tk) begin
               cmp(e.tag, "kind", {30'b0, kind}, {30'b0, e.kd});
               cmp(e.tag, "new_status", new_status, e.ns);
               cmp(e.tag, "saved_status", saved_status, e.sv);
               cmp(e.tag, "link", link_val, e.lk);
               cmp(e.tag, "vector", vector_addr, e.vc);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 5000);
      if (!done) begin
         errors++;
         $display("FAIL R9 watchdog actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      cmp("R10", "reset take", {31'b0, take}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: request high but no boundary
      drive(0, 0, 1, 1, 32'h10, 32'h100, "R9");
      // R1 R4 R6: fast entry from user mode
      drive(1, 0, 1, 0, 32'h10, 32'h200, "R1_R4_R6");
      // R1: fast masked
      drive(1, 0, 1, 0, 32'h50, 32'h204, "R1");
      // R2 R5 R6: normal entry, upper flags and bit 5 kept
      drive(1, 0, 0, 1, 32'hF000_003F, 32'h300, "R2_R5_R6");
      // R2: normal masked
      drive(1, 0, 0, 1, 32'h90, 32'h304, "R2");
      // R3: both unmasked, fast wins
      drive(1, 0, 1, 1, 32'h1F, 32'h400, "R3");
      // R3: fast preempts normal handler
      drive(1, 0, 1, 0, 32'h92, 32'h404, "R3");
      // R3: normal cannot preempt fast handler
      drive(1, 0, 0, 1, 32'hD1, 32'h408, "R3");
      // R7: reset without boundary while interrupts pending
      drive(0, 1, 1, 1, 32'h1F, 32'h500, "R7");
      // R7: reset beats a boundary with open fast request
      drive(1, 1, 1, 0, 32'h8000_0010, 32'h504, "R7");
      // R8: illegal mode at reset
      drive(0, 1, 0, 0, 32'h0000_0005, 32'h600, "R8");
      // R8: legal undefined-mode code is kept
      drive(0, 1, 0, 0, 32'h0000_009B, 32'h604, "R8");
      // R11: held line masked, then unmasked
      drive(1, 0, 0, 1, 32'h93, 32'h700, "R11");
      drive(0, 0, 0, 1, 32'h13, 32'h704, "R11");
      drive(1, 0, 0, 1, 32'h13, 32'h708, "R11");
      // R9 R10: consecutive boundaries, one entry each
      drive(1, 0, 1, 0, 32'h10, 32'h800, "R9_R10");
      drive(1, 0, 1, 0, 32'h12, 32'h804, "R9_R10");
      drive(0, 0, 0, 0, 32'h10, 32'h808, "R10");
      // R5: bit 6 left alone on normal entry
      drive(1, 0, 0, 1, 32'h70, 32'h900, "R5");
      drive(0, 0, 0, 0, 32'h10, 32'h904, "R9");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule